// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is a free-running up-counter for use as a time base or a periodic interrupt source. Software reaches it through a word-addressed register port: an address, a write strobe, write data, and read data that follows the address in the same cycle. The counter advances on every clock. It can instead advance on a divided tick from a power-of-two prescaler. When it passes its all-ones value, it either wraps to zero or reloads a programmed start value. In reload mode the overflow period is (all-ones − reload) + 1 ticks.

Each overflow sets a sticky status flag. Software clears that flag by writing a one to it. A single level interrupt output is the OR of all status flags that are enabled. A soft reset returns every register to its default value after a fixed number of cycles. Software polls a done bit to learn when the soft reset has completed. A fixed revision word identifies the block.

Top module: `prescaled_reload_timer`

## Requirements
- R1: Register word addresses are: 0 revision, 1 configuration, 2 reset status, 3 interrupt status, 4 interrupt enable, 5 control, 6 live counter, 7 reload. Reads of unused bits return 0. After the hardware reset, the following registers read 0: control, counter, reload, status and enable. Reset status bit 0 reads 1.
- R2: Address 0 always reads the revision word (default 0x00000021). Writes to address 0 have no effect.
- R3: Control bit 0 is the start bit. While it is 0, the counter holds its value. While it is 1 and control bit 5 is 0, the counter increases by one on every clock.
- R4: Control bit 5 is the prescaler enable, and control bits [4:2] hold the ratio field P. While the prescaler is enabled and start is 1, the counter advances once every 2^(P+1) clocks. The hidden prescale count clears on every control write, so the first step after such a write comes 2^(P+1) clocks later.
- R5: With auto-reload (control bit 1) clear, a tick at 0xFFFFFFFF takes the counter to 0, and counting continues.
- R6: With auto-reload set, a tick at 0xFFFFFFFF loads the reload register into the counter. The reload value used is the one held before any reload write in that same cycle.
- R7: A write to the counter address sets the count in the next cycle at any time, and this write takes priority over a tick in that cycle.
- R8: Every overflow sets status bit 0, whatever the enable register holds. Bit 1 (match) and bit 2 (capture) are never set.
- R9: A write to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. An overflow in the same cycle as a clear of bit 0 leaves bit 0 set.
- R10: The interrupt output is high exactly when some status bit and the enable bit at the same position are both 1. The enable register uses the same bit positions as the status register.
- R11: Writing 1 to configuration bit 1 starts a soft reset. For the next 4 cycles, reset status bit 0 reads 0 and configuration bit 1 reads 1. All registers read their defaults, and every write is ignored, including another soft reset. After those 4 cycles the done bit reads 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (3) | Register word address |
| we_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data of the addressed register, combinational |
| irq_o | output | 1 | Level interrupt, OR of enabled status flags |

## Verification
A wrong count, a wrong prescale phase or a wrong overflow decision appears on the counter read within one cycle of the step that went wrong. Prescale errors can stay hidden for up to 256 clocks, until the next tick is due. A lost or extra status update appears at the status read and at the interrupt pin in the next cycle. A wrong soft-reset length shows on the done bit on the exact cycle that differs. The reference model is therefore compared with the read port and the interrupt on every clock, across long runs at each prescale ratio and across wrap and reload boundaries.

// File: rtl/prt_pkg.sv
package prt_pkg;

   // register word addresses
   localparam int unsigned REG_REV = 0;
   localparam int unsigned REG_CFG = 1;
   localparam int unsigned REG_RST = 2;
   localparam int unsigned REG_STS = 3;
   localparam int unsigned REG_ENA = 4;
   localparam int unsigned REG_CTL = 5;
   localparam int unsigned REG_CNT = 6;
   localparam int unsigned REG_RLD = 7;

   // configuration and status bit positions
   localparam int unsigned CFG_SOFT  = 1;
   localparam int unsigned RST_DONE  = 0;
   localparam int unsigned NUM_FLAGS = 3;
   localparam int unsigned IRQ_OVF   = 0;
   localparam int unsigned IRQ_MAT   = 1;
   localparam int unsigned IRQ_CAP   = 2;

   localparam int unsigned PTV_W = 3;
   localparam int unsigned CTL_W = PTV_W + 3;

   // control register, bit 0 first from the right
   typedef struct packed {
      logic             ps_en;
      logic [PTV_W-1:0] ptv;
      logic             auto_rld;
      logic             run;
   } ctl_t;

endpackage

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
   parameter int unsigned PTV_W         = 3,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             restart_i,
   input  logic             run_i,
   input  logic             ps_en_i,
   input  logic [PTV_W-1:0] ptv_i,
   output logic             tick_o
);

   localparam int unsigned PS_W = 1 << PTV_W;

   generate
      if (HAS_PRESCALER) begin : g_div
         localparam logic [PS_W-1:0] ONES = '1;
         logic [PS_W-1:0] ps_q;
         logic [PS_W-1:0] term;
         logic            hit;

         // terminal count is 2^(ptv+1)-1
         assign term   = ONES >> (PTV_W'(PS_W - 1) - ptv_i);
         assign hit    = (ps_q == term);
         assign tick_o = run_i && (!ps_en_i || hit);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               ps_q <= '0;
            end else if (clr_i || restart_i) begin
               ps_q <= '0;
            end else if (run_i && ps_en_i) begin
               ps_q <= hit ? '0 : ps_q + 1'b1;
            end
         end
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = &{1'b0, clk_i, rst_ni, clr_i, restart_i, ps_en_i, ptv_i};
         assign tick_o     = run_i;
      end
   endgenerate

endmodule

// File: rtl/prt_counter.sv
module prt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             auto_rld_i,
   input  logic             cnt_we_i,
   input  logic             rld_we_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] rld_o,
   output logic             ovf_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rld_q;
   logic [CNT_W-1:0] cnt_next;
   logic             at_max;

   assign at_max = (cnt_q == CNT_MAX);
   assign ovf_o  = tick_i && at_max && !clr_i;

   always_comb begin
      cnt_next = cnt_q;
      if (cnt_we_i) begin
         cnt_next = wdata_i;
      end else if (tick_i) begin
         if (at_max) begin
            cnt_next = auto_rld_i ? rld_q : '0;
         end else begin
            cnt_next = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         rld_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
         rld_q <= '0;
      end else begin
         cnt_q <= cnt_next;
         if (rld_we_i) begin
            rld_q <= wdata_i;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign rld_o = rld_q;

endmodule

// File: rtl/prt_irq.sv
module prt_irq #(
   parameter int unsigned NFLAG = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic [NFLAG-1:0] set_i,
   input  logic             sts_we_i,
   input  logic             ena_we_i,
   input  logic [NFLAG-1:0] wdata_i,
   output logic [NFLAG-1:0] sts_o,
   output logic [NFLAG-1:0] ena_o,
   output logic             irq_o
);

   logic [NFLAG-1:0] sts_q;
   logic [NFLAG-1:0] ena_q;
   logic [NFLAG-1:0] w1c_mask;

   assign w1c_mask = sts_we_i ? wdata_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sts_q <= '0;
         ena_q <= '0;
      end else if (clr_i) begin
         sts_q <= '0;
         ena_q <= '0;
      end else begin
         // a new event wins over a clear in the same cycle
         sts_q <= (sts_q & ~w1c_mask) | set_i;
         if (ena_we_i) begin
            ena_q <= wdata_i;
         end
      end
   end

   assign sts_o = sts_q;
   assign ena_o = ena_q;
   assign irq_o = |(sts_q & ena_q);

endmodule

// File: rtl/prt_softrst.sv
module prt_softrst #(
   parameter int unsigned SR_CYCLES = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic go_i,
   output logic busy_o
);

   localparam int unsigned NW = (SR_CYCLES > 1) ? $clog2(SR_CYCLES) : 1;
   localparam logic [NW-1:0] LAST = NW'(SR_CYCLES - 1);

   logic          busy_q;
   logic [NW-1:0] n_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         n_q    <= '0;
      end else if (go_i && !busy_q) begin
         busy_q <= 1'b1;
         n_q    <= '0;
      end else if (busy_q) begin
         if (n_q == LAST) begin
            busy_q <= 1'b0;
            n_q    <= '0;
         end else begin
            n_q <= n_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;

endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
   import prt_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned CNT_W         = 32,
   parameter int unsigned ADDR_W        = 3,
   parameter int unsigned SR_CYCLES     = 4,
   parameter logic [31:0] REV_ID        = 32'h0000_0021,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);

   // elaboration-time parameter checks
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (DATA_W < CTL_W || DATA_W > 32) begin : g_bad_data
         $error("DATA_W must lie between the control width and 32");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover eight registers");
      end
      if (SR_CYCLES < 1) begin : g_bad_sr
         $error("SR_CYCLES must be at least one");
      end
   endgenerate

   logic             busy;
   logic             sr_go;
   logic             hold;
   logic             sel_cfg, sel_sts, sel_ena, sel_ctl, sel_cnt, sel_rld;
   logic             wr_ctl, wr_cnt, wr_rld, wr_sts, wr_ena;
   ctl_t             ctl_q;
   logic             tick;
   logic             ovf;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] rld;
   logic [NUM_FLAGS-1:0] sts;
   logic [NUM_FLAGS-1:0] ena;
   logic [NUM_FLAGS-1:0] set_vec;

   // address decode
   assign sel_cfg = (addr_i == ADDR_W'(REG_CFG));
   assign sel_sts = (addr_i == ADDR_W'(REG_STS));
   assign sel_ena = (addr_i == ADDR_W'(REG_ENA));
   assign sel_ctl = (addr_i == ADDR_W'(REG_CTL));
   assign sel_cnt = (addr_i == ADDR_W'(REG_CNT));
   assign sel_rld = (addr_i == ADDR_W'(REG_RLD));

   // all writes are dropped while a soft reset runs
   assign sr_go  = we_i && sel_cfg && wdata_i[CFG_SOFT] && !busy;
   assign hold   = sr_go || busy;
   assign wr_ctl = we_i && sel_ctl && !busy;
   assign wr_cnt = we_i && sel_cnt && !busy;
   assign wr_rld = we_i && sel_rld && !busy;
   assign wr_sts = we_i && sel_sts && !busy;
   assign wr_ena = we_i && sel_ena && !busy;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q <= '0;
      end else if (hold) begin
         ctl_q <= '0;
      end else if (wr_ctl) begin
         ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
      end
   end

   prt_softrst #(
      .SR_CYCLES (SR_CYCLES)
   ) u_softrst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (sr_go),
      .busy_o (busy)
   );

   prt_prescaler #(
      .PTV_W         (PTV_W),
      .HAS_PRESCALER (HAS_PRESCALER)
   ) u_prescaler (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (hold),
      .restart_i (wr_ctl),
      .run_i     (ctl_q.run),
      .ps_en_i   (ctl_q.ps_en),
      .ptv_i     (ctl_q.ptv),
      .tick_o    (tick)
   );

   prt_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (hold),
      .tick_i     (tick),
      .auto_rld_i (ctl_q.auto_rld),
      .cnt_we_i   (wr_cnt),
      .rld_we_i   (wr_rld),
      .wdata_i    (wdata_i[CNT_W-1:0]),
      .cnt_o      (cnt),
      .rld_o      (rld),
      .ovf_o      (ovf)
   );

   // event sources per status flag; only overflow is wired in this block
   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_src
         if (i == IRQ_OVF) begin : g_ovf
            assign set_vec[i] = ovf;
         end else begin : g_none
            assign set_vec[i] = 1'b0;
         end
      end
   endgenerate

   prt_irq #(
      .NFLAG (NUM_FLAGS)
   ) u_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (hold),
      .set_i    (set_vec),
      .sts_we_i (wr_sts),
      .ena_we_i (wr_ena),
      .wdata_i  (wdata_i[NUM_FLAGS-1:0]),
      .sts_o    (sts),
      .ena_o    (ena),
      .irq_o    (irq_o)
   );

   // read mux
   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_W'(REG_REV): rdata_o = DATA_W'(REV_ID);
         ADDR_W'(REG_CFG): rdata_o[CFG_SOFT] = busy;
         ADDR_W'(REG_RST): rdata_o[RST_DONE] = !busy;
         ADDR_W'(REG_STS): rdata_o[NUM_FLAGS-1:0] = sts;
         ADDR_W'(REG_ENA): rdata_o[NUM_FLAGS-1:0] = ena;
         ADDR_W'(REG_CTL): rdata_o[CTL_W-1:0] = ctl_q;
         ADDR_W'(REG_CNT): rdata_o[CNT_W-1:0] = cnt;
         ADDR_W'(REG_RLD): rdata_o[CNT_W-1:0] = rld;
         default:          rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/prt_chk.sv
module prt_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 3,
   parameter logic [31:0] REV_ID = 32'h0000_0021
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              irq_o,
   input logic              tick,
   input logic              run,
   input logic              auto_rld,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  rld,
   input logic [2:0]        sts,
   input logic [2:0]        ena,
   input logic              busy,
   input logic              sr_go,
   input logic              wr_cnt
);

   localparam logic [CNT_W-1:0] CMAX = '1;

   AST_REV_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == '0) |-> (rdata_o == DATA_W'(REV_ID))); // R2

   AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !wr_cnt && !sr_go) |=> $stable(cnt)); // R3

   AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && cnt == CMAX && !auto_rld && !wr_cnt && !sr_go) |=> (cnt == '0)); // R5

   AST_RELOAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && cnt == CMAX && auto_rld && !wr_cnt && !sr_go) |=> (cnt == $past(rld))); // R6

   AST_OVF_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && cnt == CMAX && !sr_go) |=> sts[0]); // R8

   AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ena == 3'b000) |-> !irq_o); // R10

   AST_SOFT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |-> (cnt == '0 && rld == '0 && sts == 3'b000 && ena == 3'b000 && !run)); // R11

endmodule

bind prescaled_reload_timer prt_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W),
   .REV_ID (REV_ID)
) u_prt_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .addr_i   (addr_i),
   .rdata_o  (rdata_o),
   .irq_o    (irq_o),
   .tick     (tick),
   .run      (ctl_q.run),
   .auto_rld (ctl_q.auto_rld),
   .cnt      (cnt),
   .rld      (rld),
   .sts      (sts),
   .ena      (ena),
   .busy     (busy),
   .sr_go    (sr_go),
   .wr_cnt   (wr_cnt)
);

// File: tb/prescaled_reload_timer_bench.sv
module prescaled_reload_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   prescaled_reload_timer u_prescaled_reload_timer (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .addr_i  (addr),
      .we_i    (we),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   // ---------------- behavioural reference ----------------
   logic [31:0] m_cnt = '0, m_rld = '0;
   logic [5:0]  m_ctl = '0;
   logic [2:0]  m_sts = '0, m_en = '0;
   bit          m_busy = 1'b0;
   int          m_srn = 0;
   int          m_ps = 0;

   task automatic m_defaults();
      m_cnt = '0; m_rld = '0; m_ctl = '0; m_sts = '0; m_en = '0; m_ps = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_defaults();
         m_busy = 1'b0;
         m_srn  = 0;
      end else if (m_busy) begin
         m_srn++;
         if (m_srn == 4) m_busy = 1'b0;
      end else if (we && addr == 3'd1 && wdata[1]) begin
         m_defaults();
         m_busy = 1'b1;
         m_srn  = 0;
      end else begin
         bit run, pe, ar, tk, ov;
         int div;
         run = m_ctl[0]; ar = m_ctl[1]; pe = m_ctl[5];
         div = 1 << (int'(m_ctl[4:2]) + 1);
         tk  = run && (!pe || m_ps == div - 1);
         ov  = tk && (m_cnt == 32'hFFFF_FFFF);
         if (we && addr == 3'd5) m_ps = 0;
         else if (run && pe) m_ps = tk ? 0 : m_ps + 1;
         if (we && addr == 3'd6) m_cnt = wdata;
         else if (tk) m_cnt = ov ? (ar ? m_rld : 32'd0) : m_cnt + 32'd1;
         if (we && addr == 3'd3) m_sts = m_sts & ~wdata[2:0];
         if (ov) m_sts[0] = 1'b1;
         if (we && addr == 3'd4) m_en  = wdata[2:0];
         if (we && addr == 3'd5) m_ctl = wdata[5:0];
         if (we && addr == 3'd7) m_rld = wdata;
      end
   end

   function automatic logic [31:0] m_read(logic [2:0] a);
      case (a)
         3'd0: return 32'h0000_0021;
         3'd1: return {30'd0, m_busy, 1'b0};
         3'd2: return {31'd0, !m_busy};
         3'd3: return {29'd0, m_sts};
         3'd4: return {29'd0, m_en};
         3'd5: return {26'd0, m_ctl};
         3'd6: return m_cnt;
         default: return m_rld;
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] a);
      case (a)
         3'd0: return "R2";
         3'd1, 3'd2: return "R11";
         3'd3: return "R9";
         3'd4: return "R10";
         3'd5: return "R4";
         3'd6: return "R3";
         default: return "R6";
      endcase
   endfunction

   // ---------------- stimulus helpers ----------------
   task automatic compare(string req);
      vectors++;
      if (rdata !== m_read(addr)) begin
         errors++;
         $display("FAIL %s addr=%0d rdata actual=%h expected=%h", req, addr, rdata, m_read(addr));
      end
      if (irq !== |(m_sts & m_en)) begin
         errors++;
         $display("FAIL R10 irq actual=%b expected=%b", irq, |(m_sts & m_en));
      end
   endtask

   task automatic cyc(bit w, logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      we = w; addr = a; wdata = d;
      #1 compare(rst_n ? tag_of(a) : "R1");
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      cyc(1'b1, a, d);
   endtask

   task automatic rd(logic [2:0] a, int n);
      for (int i = 0; i < n; i++) cyc(1'b0, a, 32'hDEAD_BEEF);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      repeat (3) @(posedge clk);
      // R1: reset values at every address while reset is held
      for (int a = 0; a < 8; a++) cyc(1'b0, 3'(a), '0);
      @(negedge clk); rst_n = 1'b1;
      for (int a = 0; a < 8; a++) cyc(1'b0, 3'(a), '0);

      // R2: revision is read-only
      wr(3'd0, 32'h1234_5678);
      rd(3'd0, 2);

      // R3: stopped counter holds, running counter steps each clock
      wr(3'd6, 32'd100);
      rd(3'd6, 5);
      wr(3'd5, 32'h1);
      rd(3'd6, 10);
      wr(3'd5, 32'h0);
      rd(3'd6, 4);

      // R5 and R8: wrap to zero without reload, flag set with enable off
      wr(3'd6, 32'hFFFF_FFFC);
      wr(3'd5, 32'h1);
      rd(3'd6, 8);
      rd(3'd3, 2);

      // R10: enable only match bit -> no irq; overflow bit -> irq
      wr(3'd4, 32'h2);
      rd(3'd3, 2);
      wr(3'd4, 32'h1);
      rd(3'd4, 2);

      // R9: writing zeros keeps the flag, writing one clears it
      wr(3'd3, 32'h0);
      rd(3'd3, 2);
      wr(3'd3, 32'h1);
      rd(3'd3, 2);
      // R9: clear written on the overflow cycle loses to the new event
      wr(3'd6, 32'hFFFF_FFFD);
      for (int i = 0; i < 6; i++) wr(3'd3, 32'h7);
      rd(3'd3, 2);
      wr(3'd3, 32'h1);

      // R6: auto-reload period of 16 ticks
      wr(3'd7, 32'hFFFF_FFF0);
      wr(3'd6, 32'hFFFF_FFFE);
      wr(3'd5, 32'h3);
      rd(3'd6, 40);
      // R6: reload written in the overflow cycle does not take effect yet
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FF00);
      rd(3'd6, 4);
      rd(3'd7, 1);

      // R4: prescale ratios 2, 8 and 256, with a free-running count
      wr(3'd6, 32'hFFFF_FFF8);
      wr(3'd5, 32'h21);
      rd(3'd6, 30);
      wr(3'd5, 32'h29);
      rd(3'd6, 80);
      rd(3'd5, 1);
      wr(3'd5, 32'h3D);
      rd(3'd6, 600);
      // R4: prescaler enable off again runs at full rate
      wr(3'd5, 32'h1C);
      rd(3'd6, 3);
      wr(3'd5, 32'h1D);
      rd(3'd6, 5);

      // R7: counter write while running takes priority over the tick
      wr(3'd6, 32'h0000_0500);
      rd(3'd6, 3);
      wr(3'd6, 32'hFFFF_FFFF);
      rd(3'd6, 3);
      rd(3'd3, 1);

      // R11: configuration write without bit 1 does nothing
      wr(3'd4, 32'h5);
      wr(3'd1, 32'h1);
      rd(3'd2, 2);
      rd(3'd6, 1);
      // R11: soft reset, writes ignored while busy, done after 4 cycles
      wr(3'd7, 32'hABCD_0000);
      wr(3'd1, 32'h2);
      wr(3'd1, 32'h2);
      wr(3'd5, 32'h1);
      wr(3'd6, 32'h55);
      cyc(1'b0, 3'd2, '0);
      rd(3'd2, 3);
      for (int a = 0; a < 8; a++) cyc(1'b0, 3'(a), '0);
      // R11: block works normally afterwards
      wr(3'd5, 32'h1);
      rd(3'd6, 5);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule